// File: doc/BRIEF.md
# Serial Flash Write-Gating and Block-Protect Controller

This block decides whether a serial flash may modify its array or its protect settings. A command decoder upstream hands it one strobe per chip-select rise. The strobe carries the opcode, the 24-bit address, a flag that says whether the select rose on a byte boundary, the number of data bytes clocked in after the address, and the first data byte. The block also samples the write-protect pin. It holds the status register: the busy flag, the write-enable latch, three protect-size bits, a top/bottom select and a register lock bit.

A write request is accepted only if the write-enable latch is set, the select rose on a byte boundary and the device is idle. It must also pass its own gate: the target address lies outside the protected range, the array is fully unprotected for a chip erase, or the lock and the write-protect pin permit a status write. An accepted request starts a timer whose length depends on the operation and is given by a parameter. The busy flag stays high while the timer runs. When the timer expires, the write-enable latch clears, and for a status write the new protect settings take effect. The array itself and the nonvolatile cells are not part of this block. The protect settings come up as zero at reset.

Top module: `flash_write_gate`

## Requirements
- R1: After reset, status reads 00h and busy is 0. The status byte layout is: bit0 busy, bit1 write-enable, bits 4:2 protect size BP2..BP0, bit5 top/bottom select, bit6 always 0, bit7 register lock.
- R2: Opcode 06h sets write-enable and opcode 04h clears it. Both need a byte-aligned select rise. Read-type opcodes (for example 03h) leave the status unchanged.
- R3: The write opcodes are 20h/D7h (small erase), D8h (sector erase), 60h/C7h (chip erase), 02h (program) and 01h (status write). Each is rejected when write-enable is 0 or the select rise is not byte aligned. A rejected command leaves write-enable unchanged.
- R4: An accepted write raises busy (status bit0) at the clock edge that samples the strobe. Busy stays high for exactly the parameter cycles of that operation. Write-enable reads 0 once busy falls.
- R5: Protect decode, for address bits 18:0. BP=000 protects nothing. With top/bottom select 0, BP 001/010/011 protects 070000h–07FFFFh, 060000h–07FFFFh and 040000h–07FFFFh. With select 1, BP 101/110/111 protects 000000h–00FFFFh, 000000h–01FFFFh and 000000h–03FFFFh. Every other nonzero combination protects the whole array.
- R6: An erase or program whose address falls in the protected range is rejected. Address bits 23:19 are ignored.
- R7: A chip erase is accepted only when BP=000.
- R8: A status write is rejected when the lock bit is 1 and the write-protect pin is low. With the pin high, the lock bit does not matter.
- R9: A status write needs exactly one data byte. When it completes, bits 7 and 5:2 take the data byte's values, and bits 0, 1 and 6 are unaffected by the data.
- R10: A program needs at least one data byte. Any longer count, including more than 256 bytes, is accepted.
- R11: While busy, every command, including 06h and 04h, is ignored, and the running timer is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe: a command ended with a select rise |
| cmd_opcode | input | 8 | Command opcode |
| cmd_addr | input | 24 | Command address |
| cmd_aligned | input | 1 | Select rose on a byte boundary |
| cmd_nbytes | input | NB_W (12) | Data bytes received after opcode/address |
| cmd_wdata | input | 8 | First data byte (status write value) |
| wp_n | input | 1 | Write-protect pin, active low |
| status | output | 8 | Status register byte |
| busy | output | 1 | Internal write in progress |

## Verification
The hardest case to reach is a command that arrives while a write is still in progress. The bench must show that such a command neither restarts the timer nor changes write-enable. A directed sequence starts a program and then, inside the busy window, sends a write-disable and then a sector erase. It checks that write-enable still reads 1 mid-window and that busy falls on exactly the programmed cycle. Reaching each protect level also takes an accepted status write that has run to completion. So the vector table chains write-enable, status write and wait steps before each protected-address probe.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WEN,
        OP_WDI,
        OP_SSE,
        OP_SE,
        OP_CE,
        OP_PP,
        OP_SRW
    } op_kind_e;

    typedef enum logic [1:0] {
        PL_NONE,
        PL_TOP,
        PL_BOT,
        PL_ALL
    } prot_lvl_e;

    typedef struct packed {
        logic       lock;
        logic       rsv;
        logic       tb;
        logic [2:0] bp;
        logic       wen;
        logic       busy;
    } stat_t;

    function automatic op_kind_e classify(input logic [7:0] op);
        case (op)
            8'h06:        return OP_WEN;
            8'h04:        return OP_WDI;
            8'h20, 8'hD7: return OP_SSE;
            8'hD8:        return OP_SE;
            8'h60, 8'hC7: return OP_CE;
            8'h02:        return OP_PP;
            8'h01:        return OP_SRW;
            default:      return OP_NONE;
        endcase
    endfunction

    function automatic logic is_write(input op_kind_e k);
        return (k == OP_SSE) || (k == OP_SE) || (k == OP_CE) ||
               (k == OP_PP)  || (k == OP_SRW);
    endfunction

    function automatic prot_lvl_e prot_level(input logic tb, input logic [2:0] bp);
        if (bp == 3'b000)                    return PL_NONE;
        if (!tb && !bp[2])                   return PL_TOP;
        if (tb && bp[2] && bp[1:0] != 2'b00) return PL_BOT;
        return PL_ALL;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fwg_protect.sv
module fwg_protect
    import fwg_pkg::*;
#(
    parameter int AW = 19
) (
    input  logic          tb,
    input  logic [2:0]    bp,
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic          level_zero
);
    localparam int SH_BASE = AW - 4;

    logic [AW:0] full;
    logic [AW:0] rsize;
    logic [AW:0] a_ext;
    prot_lvl_e   lvl;

    always_comb begin
        full  = {1'b1, {AW{1'b0}}};
        rsize = {{AW{1'b0}}, 1'b1} << (SH_BASE + int'(bp[1:0]));
        a_ext = {1'b0, addr};
        lvl   = prot_level(tb, bp);
        case (lvl)
            PL_NONE: hit = 1'b0;
            PL_TOP:  hit = (a_ext >= (full - rsize));
            PL_BOT:  hit = (a_ext < rsize);
            default: hit = 1'b1;
        endcase
        level_zero = (lvl == PL_NONE);
    end
endmodule

// File: rtl/fwg_gate.sv
module fwg_gate
    import fwg_pkg::*;
#(
    parameter int NB_W = 12
) (
    input  logic            cmd_valid,
    input  op_kind_e        kind,
    input  logic            aligned,
    input  logic [NB_W-1:0] nbytes,
    input  logic            busy,
    input  logic            wen,
    input  logic            lock,
    input  logic            wp_n,
    input  logic            hit,
    input  logic            level_zero,
    output logic            start,
    output logic            wen_set,
    output logic            wen_clr
);
    logic common_ok;
    logic kind_ok;

    always_comb begin
        common_ok = cmd_valid && !busy && aligned;
        case (kind)
            OP_SSE, OP_SE: kind_ok = !hit;
            OP_CE:         kind_ok = level_zero;
            OP_PP:         kind_ok = !hit && (nbytes != '0);
            OP_SRW:        kind_ok = (nbytes == NB_W'(1)) && (wp_n || !lock);
            default:       kind_ok = 1'b0;
        endcase
        start   = common_ok && wen && is_write(kind) && kind_ok;
        wen_set = common_ok && (kind == OP_WEN);
        wen_clr = common_ok && (kind == OP_WDI);
    end
endmodule

// File: rtl/fwg_timer.sv
module fwg_timer
    import fwg_pkg::*;
#(
    parameter int T_SSE = 20,
    parameter int T_SE  = 30,
    parameter int T_CE  = 40,
    parameter int T_PP  = 16,
    parameter int T_SRW = 12
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  op_kind_e kind,
    output logic     busy,
    output logic     done
);
    localparam int TMAX = max_of(max_of(max_of(T_SSE, T_SE), max_of(T_CE, T_PP)), T_SRW);
    localparam int CW   = $clog2(TMAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] dur;

    always_comb begin
        case (kind)
            OP_SSE:  dur = CW'(T_SSE);
            OP_SE:   dur = CW'(T_SE);
            OP_CE:   dur = CW'(T_CE);
            OP_PP:   dur = CW'(T_PP);
            OP_SRW:  dur = CW'(T_SRW);
            default: dur = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= dur;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

    // R11: the gate never launches an operation over a running one
    assert_idle_start_R11: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
endmodule

// File: rtl/flash_write_gate.sv
module flash_write_gate
    import fwg_pkg::*;
#(
    parameter int AW    = 19,
    parameter int NB_W  = 12,
    parameter int T_SSE = 20,
    parameter int T_SE  = 30,
    parameter int T_CE  = 40,
    parameter int T_PP  = 16,
    parameter int T_SRW = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [7:0]      cmd_opcode,
    input  logic [23:0]     cmd_addr,
    input  logic            cmd_aligned,
    input  logic [NB_W-1:0] cmd_nbytes,
    input  logic [7:0]      cmd_wdata,
    input  logic            wp_n,
    output logic [7:0]      status,
    output logic            busy
);
    op_kind_e   kind;
    logic       wen_q, lock_q, tb_q;
    logic [2:0] bp_q;
    logic       srw_pend;
    logic       lock_nx, tb_nx;
    logic [2:0] bp_nx;
    logic       hit, level_zero;
    logic       start, wen_set, wen_clr, done;
    logic       unused_bits;
    stat_t      st;

    assign kind        = classify(cmd_opcode);
    assign unused_bits = ^{cmd_addr[23:AW]};

    fwg_protect #(.AW(AW)) u_protect (
        .tb(tb_q), .bp(bp_q), .addr(cmd_addr[AW-1:0]),
        .hit(hit), .level_zero(level_zero)
    );

    fwg_gate #(.NB_W(NB_W)) u_gate (
        .cmd_valid(cmd_valid), .kind(kind), .aligned(cmd_aligned),
        .nbytes(cmd_nbytes), .busy(busy), .wen(wen_q), .lock(lock_q),
        .wp_n(wp_n), .hit(hit), .level_zero(level_zero),
        .start(start), .wen_set(wen_set), .wen_clr(wen_clr)
    );

    fwg_timer #(.T_SSE(T_SSE), .T_SE(T_SE), .T_CE(T_CE), .T_PP(T_PP), .T_SRW(T_SRW)) u_timer (
        .clk(clk), .rst(rst), .start(start), .kind(kind),
        .busy(busy), .done(done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wen_q    <= 1'b0;
            lock_q   <= 1'b0;
            tb_q     <= 1'b0;
            bp_q     <= 3'b000;
            srw_pend <= 1'b0;
            lock_nx  <= 1'b0;
            tb_nx    <= 1'b0;
            bp_nx    <= 3'b000;
        end else if (done) begin
            wen_q <= 1'b0;
            if (srw_pend) begin
                lock_q   <= lock_nx;
                tb_q     <= tb_nx;
                bp_q     <= bp_nx;
                srw_pend <= 1'b0;
            end
        end else if (start) begin
            if (kind == OP_SRW) begin
                srw_pend <= 1'b1;
                lock_nx  <= cmd_wdata[7];
                tb_nx    <= cmd_wdata[5];
                bp_nx    <= cmd_wdata[4:2];
            end
        end else if (wen_set) begin
            wen_q <= 1'b1;
        end else if (wen_clr) begin
            wen_q <= 1'b0;
        end
    end

    always_comb begin
        st.lock = lock_q;
        st.rsv  = 1'b0;
        st.tb   = tb_q;
        st.bp   = bp_q;
        st.wen  = wen_q;
        st.busy = busy;
        status  = st;
    end

    // R3: a write only launches with the enable latch set
    assert_start_wen_R3: assert property (@(posedge clk) disable iff (rst)
        start |-> wen_q);

    // R4: enable latch reads clear once the operation finishes
    assert_wen_drop_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !status[1]);

    // R7: chip erase launches only with nothing protected
    assert_chip_lvl0_R7: assert property (@(posedge clk) disable iff (rst)
        (start && kind == OP_CE) |-> (bp_q == 3'b000));

    // R8: lock with pin low blocks status writes
    assert_lock_R8: assert property (@(posedge clk) disable iff (rst)
        (start && kind == OP_SRW) |-> (wp_n || !lock_q));

    // R9: protect settings move only at completion of a status write
    assert_prot_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable({lock_q, tb_q, bp_q}));
endmodule

// File: tb/flash_write_gate_bench.sv
`timescale 1ns/1ps
module flash_write_gate_bench;
    localparam int NB_W = 12;
    localparam int T_PP = 16;
    localparam int WAIT = 48;
    localparam int NV   = 29;

    typedef struct packed {
        logic [7:0]      op;
        logic [23:0]     addr;
        logic            al;
        logic [NB_W-1:0] nb;
        logic [7:0]      data;
        logic            wp;
        logic            ebusy;
        logic [7:0]      estat;
    } vec_t;

    // op, addr, aligned, nbytes, data, wp_n, expected busy, expected status after
    localparam vec_t VEC [NV] = '{
        '{8'h06, 24'h000000, 1'b1, 12'd0,   8'h00, 1'b1, 1'b0, 8'h02}, // R2
        '{8'h04, 24'h000000, 1'b1, 12'd0,   8'h00, 1'b1, 1'b0, 8'h00}, // R2
        '{8'h02, 24'h001000, 1'b1, 12'd4,   8'h00, 1'b1, 1'b0, 8'h00}, // R3 no wen
        '{8'h06, 24'h000000, 1'b1, 12'd0,   8'h00, 1'b1, 1'b0, 8'h02},
        '{8'h02, 24'h001000, 1'b1, 12'd4,   8'h00, 1'b1, 1'b1, 8'h00}, // R4
        '{8'h06, 24'h000000, 1'b1, 12'd0,   8'h00, 1'b1, 1'b0, 8'h02},
        '{8'h02, 24'h001000, 1'b0, 12'd4,   8'h00, 1'b1, 1'b0, 8'h02}, // R3 unaligned
        '{8'h01, 24'h000000, 1'b1, 12'd2,   8'h84, 1'b1, 1'b0, 8'h02}, // R9 two bytes
        '{8'h01, 24'h000000, 1'b1, 12'd1,   8'h84, 1'b1, 1'b1, 8'h84}, // R9 top 1/8
        '{8'h06, 24'h000000, 1'b1, 12'd0,   8'h00, 1'b1, 1'b0, 8'h86},
        '{8'hD8, 24'h070000, 1'b1, 12'd0,   8'h00, 1'b1, 1'b0, 8'h86}, // R5 R6
        '{8'h20, 24'h06F000, 1'b1, 12'd0,   8'h00, 1'b1, 1'b1, 8'h84}, // R5 R6
        '{8'h06, 24'h000000, 1'b1, 12'd0,   8'h00, 1'b1, 1'b0, 8'h86},
        '{8'hD8, 24'hF70000, 1'b1, 12'd0,   8'h00, 1'b1, 1'b0, 8'h86}, // R6 high bits
        '{8'h60, 24'h000000, 1'b1, 12'd0,   8'h00, 1'b1, 1'b0, 8'h86}, // R7
        '{8'h01, 24'h000000, 1'b1, 12'd1,   8'h00, 1'b0, 1'b0, 8'h86}, // R8 locked
        '{8'h01, 24'h000000, 1'b1, 12'd1,   8'hB8, 1'b1, 1'b1, 8'hB8}, // R8 pin high
        '{8'h06, 24'h000000, 1'b1, 12'd0,   8'h00, 1'b1, 1'b0, 8'hBA},
        '{8'h02, 24'h01FFF0, 1'b1, 12'd300, 8'h00, 1'b1, 1'b0, 8'hBA}, // R5 bottom
        '{8'h02, 24'h020000, 1'b1, 12'd300, 8'h00, 1'b1, 1'b1, 8'hB8}, // R10 >256
        '{8'h06, 24'h000000, 1'b1, 12'd0,   8'h00, 1'b1, 1'b0, 8'hBA},
        '{8'h01, 24'h000000, 1'b1, 12'd1,   8'h1C, 1'b1, 1'b1, 8'h1C}, // R5 whole
        '{8'h06, 24'h000000, 1'b1, 12'd0,   8'h00, 1'b1, 1'b0, 8'h1E},
        '{8'hD7, 24'h000000, 1'b1, 12'd0,   8'h00, 1'b1, 1'b0, 8'h1E}, // R5 whole
        '{8'h03, 24'h000100, 1'b1, 12'd5,   8'h00, 1'b1, 1'b0, 8'h1E}, // R2 read
        '{8'h01, 24'h000000, 1'b1, 12'd1,   8'h43, 1'b1, 1'b1, 8'h00}, // R9 ro bits
        '{8'h06, 24'h000000, 1'b1, 12'd0,   8'h00, 1'b1, 1'b0, 8'h02},
        '{8'h02, 24'h000000, 1'b1, 12'd0,   8'h00, 1'b1, 1'b0, 8'h02}, // R10 zero
        '{8'hC7, 24'h000000, 1'b1, 12'd0,   8'h00, 1'b1, 1'b1, 8'h00}  // R7 level 0
    };

    logic            clk = 1'b0;
    logic            rst;
    logic            cmd_valid;
    logic [7:0]      cmd_opcode;
    logic [23:0]     cmd_addr;
    logic            cmd_aligned;
    logic [NB_W-1:0] cmd_nbytes;
    logic [7:0]      cmd_wdata;
    logic            wp_n;
    logic [7:0]      status;
    logic            busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    flash_write_gate #(.NB_W(NB_W), .T_PP(T_PP)) u_flash_write_gate (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_addr(cmd_addr), .cmd_aligned(cmd_aligned), .cmd_nbytes(cmd_nbytes),
        .cmd_wdata(cmd_wdata), .wp_n(wp_n), .status(status), .busy(busy)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge, after the sampling edge
    task automatic pulse(input logic [7:0] op, input logic [23:0] addr, input logic al,
                         input logic [NB_W-1:0] nb, input logic [7:0] d, input logic wp);
        cmd_opcode  = op;
        cmd_addr    = addr;
        cmd_aligned = al;
        cmd_nbytes  = nb;
        cmd_wdata   = d;
        wp_n        = wp;
        cmd_valid   = 1'b1;
        @(negedge clk);
        cmd_valid   = 1'b0;
        wp_n        = 1'b1;
    endtask

    initial begin
        #(4 * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_opcode = '0; cmd_addr = '0;
        cmd_aligned = 1'b1; cmd_nbytes = '0; cmd_wdata = '0; wp_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 status", status, 8'h00);
        check("R1 busy", {7'd0, busy}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            pulse(VEC[i].op, VEC[i].addr, VEC[i].al, VEC[i].nb, VEC[i].data, VEC[i].wp);
            check($sformatf("R3/R4 busy v%0d", i), {7'd0, busy}, {7'd0, VEC[i].ebusy});
            repeat (WAIT) @(negedge clk);
            check($sformatf("R2/R5-R10 status v%0d", i), status, VEC[i].estat);
        end

        // R11: commands inside a busy window are dropped, timer not restarted
        pulse(8'h06, 24'h0, 1'b1, '0, 8'h00, 1'b1);
        check("R2 wen set", status, 8'h02);
        pulse(8'h02, 24'h000100, 1'b1, 12'd1, 8'h00, 1'b1);
        check("R4 busy k0", {7'd0, busy}, 8'h01);
        pulse(8'h04, 24'h0, 1'b1, '0, 8'h00, 1'b1);
        check("R11 wdi ignored", status, 8'h03);
        pulse(8'hD8, 24'h000000, 1'b1, '0, 8'h00, 1'b1);
        check("R11 busy k2", {7'd0, busy}, 8'h01);
        repeat (T_PP - 3) @(negedge clk);
        check("R4 busy last cycle", {7'd0, busy}, 8'h01);
        @(negedge clk);
        check("R4 R11 busy falls on time", status, 8'h00);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule